// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block produces all bit-rate timing for a serial port. A 32-bit control word is written through a single write strobe. Its upper half holds a 16-bit oscillator increment, bit 0 turns the transmit timing on and bit 1 turns the receive timing on. Each system clock a 16-bit phase accumulator adds the increment. Every carry out of the accumulator is one tick at sixteen times the bit rate, so the bit rate equals increment × f_clk / 2^20. The rate is a fraction of the clock rather than an integer division of it.

On the transmit side, sixteen oversample ticks make one bit-period strobe. A frame counter then flags the strobe that closes each 10-bit character: one start bit, eight data bits and one stop bit. The receive side gets the raw oversample tick, gated by its own enable, and uses it to find bit centres. Every control write restarts the accumulator and both counters from zero, so new timing starts from a clean phase.

Top module: `uart_bitclock`

## Requirements
- R1: After reset, all four outputs are low and stay low until a control word is written, because the reset increment is zero.
- R2: After a control write with increment K in bits 31:16, the number of cycles with `os_tick_o` high among the N cycles after the write edge is floor(N·K / 65536). The first tick follows the edge whose addition first carries.
- R3: With an increment of zero, `os_tick_o`, `rx_os_tick_o`, `tx_bit_stb_o` and `tx_char_done_o` never go high.
- R4: With transmit enabled (bit 0 = 1), `tx_bit_stb_o` pulses for one cycle, one cycle after every sixteenth oversample tick. With K = 0x8000 the first strobe appears 33 cycles after the write edge.
- R5: `tx_char_done_o` is high only together with `tx_bit_stb_o`, on every tenth bit strobe. With K = 0x8000 the first one appears 321 cycles after the write edge.
- R6: With transmit disabled (bit 0 = 0), no bit strobe and no character strobe occur, while oversample ticks continue.
- R7: `rx_os_tick_o` equals `os_tick_o` when receive is enabled (bit 1 = 1) and is held low otherwise.
- R8: Every control write clears the accumulator, the oversample counter and the frame counter. Rewriting the same increment in mid-phase therefore delays the next tick and the next bit strobe to their from-zero positions.
- R9: Only bits 31:16, 1 and 0 of the control word have an effect. Bits 15:2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: [31:16] increment, [1] receive enable, [0] transmit enable |
| os_tick_o | output | 1 | 16x oversample tick (accumulator carry) |
| rx_os_tick_o | output | 1 | Oversample tick gated by receive enable |
| tx_bit_stb_o | output | 1 | One-cycle strobe per transmit bit period |
| tx_char_done_o | output | 1 | Strobe on the last bit period of a 10-bit character |

## Verification
The bench builds the block with its defaults: a 16-bit increment, an oversample ratio of 16 and a 10-bit frame. These values keep a full character within a few hundred cycles at mid-range increments. With an increment of 0x8000, a tick comes every two cycles, a bit every 32 and a character every 320, so exact first-strobe positions and the phase restart can be checked cycle by cycle. Extreme increments (0x0100, 0x1234, 0xFFFF, zero) check the fractional tick count against the floor formula.

// File: rtl/uart_bitclock_pkg.sv
// Package: shared widths and control-word field positions for the
// bit-rate tick generator. Assumes a 32-bit control word.
package uart_bitclock_pkg;
    localparam int CTRL_W       = 32;
    localparam int NCO_W        = 16;
    localparam int NCO_LSB      = 16;
    localparam int TX_EN_BIT    = 0;
    localparam int RX_EN_BIT    = 1;
    localparam int OS_RATE      = 16;
    localparam int FRAME_BITS   = 10;

    typedef struct packed {
        logic [NCO_W-1:0] nco;
        logic             rx_en;
        logic             tx_en;
    } bitclk_cfg_t;
endpackage

// File: rtl/uart_bitclock_cfg.sv
// Control holder: captures the increment and the two enables from a
// control word on each write, and flags a timing restart on that write.
// Assumes the field positions in the package; other bits are dropped.
module uart_bitclock_cfg
    import uart_bitclock_pkg::*;
#(
    parameter int CW  = CTRL_W,
    parameter int NW  = NCO_W,
    parameter int NLSB = NCO_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [CW-1:0] wdata_i,
    output logic [NW-1:0] nco_o,
    output logic          tx_en_o,
    output logic          rx_en_o,
    output logic          restart_o
);
    logic [NW-1:0] nco_q;
    logic          tx_q;
    logic          rx_q;

    // Latch the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nco_q <= '0;
            tx_q  <= 1'b0;
            rx_q  <= 1'b0;
        end else if (we_i) begin
            nco_q <= wdata_i[NLSB +: NW];
            tx_q  <= wdata_i[TX_EN_BIT];
            rx_q  <= wdata_i[RX_EN_BIT];
        end
    end

    // Any write restarts the timing chain in the same edge.
    always_comb restart_o = we_i;

    assign nco_o   = nco_q;
    assign tx_en_o = tx_q;
    assign rx_en_o = rx_q;

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(nco_o) && $stable(tx_en_o) && $stable(rx_en_o)));
endmodule

// File: rtl/uart_bitclock_phase.sv
// Phase accumulator: adds the increment every clock. The carry out of
// each addition is registered as one oversample tick. Assumes restart_i
// is a single-cycle pulse; it zeroes the phase.
module uart_bitclock_phase #(
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [NW-1:0] nco_i,
    output logic          tick_o
);
    logic [NW-1:0] acc_q;
    logic          tick_q;
    logic [NW:0]   sum;

    // Widened sum so the carry is kept.
    always_comb sum = {1'b0, acc_q} + {1'b0, nco_i};

    // Advance the phase and register the carry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum[NW-1:0];
            tick_q <= sum[NW];
        end
    end

    assign tick_o = tick_q;

    p_zero_nco_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nco_i == '0) |=> !tick_o);
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!tick_o && acc_q == '0));
endmodule

// File: rtl/uart_bitclock_div.sv
// Event divider: counts enable pulses modulo DIV. It flags the pulse that
// completes each group, either registered (one cycle late) or combinational
// (same cycle), as REG_OUT selects. Assumes DIV >= 2.
module uart_bitclock_div #(
    parameter int DIV     = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    output logic stb_o
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // The current pulse closes a group.
    always_comb wrap = en_i && (cnt_q == LAST);

    // Count pulses, wrapping at the group size.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            logic stb_q;
            // Delay the group-complete flag by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) stb_q <= 1'b0;
                else                   stb_q <= wrap;
            end
            assign stb_o = stb_q;

            p_stb_after_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
                stb_o |-> $past(en_i));
        end else begin : g_comb
            assign stb_o = wrap;

            p_stb_with_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
                stb_o |-> en_i);
        end
    endgenerate

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/uart_bitclock.sv
// Bit-rate tick generator top: the control holder feeds the phase
// accumulator. The accumulator's carry feeds the receive tick directly
// and, via two dividers, the transmit bit and character strobes.
// Assumes a single clock domain and a synchronous active-low reset.
module uart_bitclock
    import uart_bitclock_pkg::*;
#(
    parameter int CW         = CTRL_W,
    parameter int NW         = NCO_W,
    parameter int NLSB       = NCO_LSB,
    parameter int OS         = OS_RATE,
    parameter int FRAME      = FRAME_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [CW-1:0] ctrl_wdata,
    output logic          os_tick_o,
    output logic          rx_os_tick_o,
    output logic          tx_bit_stb_o,
    output logic          tx_char_done_o
);
    bitclk_cfg_t cfg;
    logic        restart;
    logic        os_tick;
    logic        bit_stb;
    logic        char_done;
    logic        tx_os_en;

    uart_bitclock_cfg #(.CW(CW), .NW(NW), .NLSB(NLSB)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (ctrl_we),
        .wdata_i   (ctrl_wdata),
        .nco_o     (cfg.nco),
        .tx_en_o   (cfg.tx_en),
        .rx_en_o   (cfg.rx_en),
        .restart_o (restart)
    );

    uart_bitclock_phase #(.NW(NW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .nco_i     (cfg.nco),
        .tick_o    (os_tick)
    );

    // Transmit bit timing runs only while transmit is enabled.
    always_comb tx_os_en = os_tick && cfg.tx_en;

    uart_bitclock_div #(.DIV(OS), .REG_OUT(1'b1)) u_bitdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .en_i    (tx_os_en),
        .stb_o   (bit_stb)
    );

    uart_bitclock_div #(.DIV(FRAME), .REG_OUT(1'b0)) u_framediv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .en_i    (bit_stb),
        .stb_o   (char_done)
    );

    assign os_tick_o      = os_tick;
    assign rx_os_tick_o   = os_tick && cfg.rx_en;
    assign tx_bit_stb_o   = bit_stb;
    assign tx_char_done_o = char_done;

    p_char_on_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_char_done_o |-> tx_bit_stb_o);
    p_tx_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.tx_en |=> !tx_bit_stb_o);
    p_rx_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_os_tick_o |-> (os_tick_o && cfg.rx_en));
endmodule

// File: tb/uart_bitclock_test.sv
module uart_bitclock_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        os_tick_o, rx_os_tick_o, tx_bit_stb_o, tx_char_done_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int n_os, n_rx, n_bit, n_chr, first_os, first_bit, first_chr, bad_chr;

    always #2 clk = ~clk;

    uart_bitclock uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .os_tick_o(os_tick_o), .rx_os_tick_o(rx_os_tick_o),
        .tx_bit_stb_o(tx_bit_stb_o), .tx_char_done_o(tx_char_done_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write the control word; returns at the negedge after the write edge.
    task automatic write_ctrl(input logic [31:0] w);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // Observe n cycles at negedges, counting strobes and first positions.
    task automatic observe(input int n);
        n_os = 0; n_rx = 0; n_bit = 0; n_chr = 0; bad_chr = 0;
        first_os = 0; first_bit = 0; first_chr = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (os_tick_o) begin n_os++; if (first_os == 0) first_os = k; end
            if (rx_os_tick_o) n_rx++;
            if (rx_os_tick_o != os_tick_o && rx_os_tick_o) bad_chr++;
            if (tx_bit_stb_o) begin n_bit++; if (first_bit == 0) first_bit = k; end
            if (tx_char_done_o) begin
                n_chr++;
                if (first_chr == 0) first_chr = k;
                if (!tx_bit_stb_o) bad_chr++;
            end
        end
    endtask

    function automatic longint ticks(input longint n, input longint k);
        return (n * k) >> 16;
    endfunction

    task automatic t_reset;
        observe(100);
        check("R1 os ticks after reset", n_os, 0);
        check("R1 rx ticks after reset", n_rx, 0);
        check("R1 bit strobes after reset", n_bit, 0);
        check("R1 char strobes after reset", n_chr, 0);
    endtask

    task automatic t_rate(input logic [15:0] k, input int n);
        write_ctrl({k, 16'h0003});
        observe(n);
        check($sformatf("R2 tick count K=%0h", k), n_os, ticks(n, k));
        check($sformatf("R7 rx follows tick K=%0h", k), n_rx, n_os);
        check($sformatf("R4 bit count K=%0h", k), n_bit, ticks(n - 1, k) / 16);
        check($sformatf("R5 char count K=%0h", k), n_chr, (ticks(n - 1, k) / 16) / 10);
        check($sformatf("R5 char only with bit K=%0h", k), bad_chr, 0);
    endtask

    task automatic t_exact;
        write_ctrl(32'h8000_0001);
        observe(700);
        check("R2 first tick position", first_os, 2);
        check("R4 first bit strobe position", first_bit, 33);
        check("R5 first char strobe position", first_chr, 321);
        check("R7 rx disabled gives no rx ticks", n_rx, 0);
        check("R5 chars in 700 cycles", n_chr, 2);
    endtask

    task automatic t_zero;
        write_ctrl(32'h0000_0003);
        observe(300);
        check("R3 zero increment ticks", n_os, 0);
        check("R3 zero increment bits", n_bit, 0);
        check("R3 zero increment rx", n_rx, 0);
    endtask

    task automatic t_tx_off;
        write_ctrl(32'h8000_0002);
        observe(400);
        check("R6 ticks continue with tx off", n_os, 200);
        check("R6 no bit strobes with tx off", n_bit, 0);
        check("R6 no char strobes with tx off", n_chr, 0);
        check("R7 rx ticks with rx on", n_rx, 200);
    endtask

    task automatic t_restart;
        write_ctrl(32'h8000_0001);
        observe(47);
        write_ctrl(32'h8000_0001);
        observe(40);
        check("R8 tick phase restarts", first_os, 2);
        check("R8 bit counter restarts", first_bit, 33);
    endtask

    task automatic t_ignored;
        write_ctrl(32'h8000_FFFC);
        observe(100);
        check("R9 upper field used, low bits ignored", n_os, 50);
        check("R9 bits 15:2 leave tx off", n_bit, 0);
        check("R9 bits 15:2 leave rx off", n_rx, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate(16'h8000, 100);
        t_rate(16'h0100, 1000);
        t_rate(16'h1234, 3000);
        t_rate(16'hFFFF, 5000);
        t_exact();
        t_zero();
        t_tx_off();
        t_restart();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule